// File: doc/BRIEF.md
# TPM SPI Transaction Sequencer

This block is the host side of a framed SPI link to a trusted-platform-module style target. A client gives it one command with a direction, a 4-bit locality, a 12-bit register offset and a byte count. The block then drives SCLK, chip select and MOSI, and samples MISO, to move that many bytes to or from the target register. Write bytes arrive on an input byte stream. Read bytes leave on an output byte stream in the order they came off the wire.

Every frame begins with a four-byte header. The header gives the direction, the frame's size, a fixed tag and the 16-bit address. The target may hold off the data phase with flow-control bytes, and the engine polls them for a ready flag under a bounded timeout. A command longer than the frame limit goes out as a run of frames, each with its own header. The engine is busy for the whole command and reports once at the end with a status code.

Top module: `tpm_spi_seq`

## Requirements
- R1: Header byte 0 is `{dir, size-1}`: bit 7 is 1 for a read and 0 for a write, and bits 6:0 hold the frame's data byte count minus one. Header byte 1 is always 0xD4.
- R2: Header bytes 2 and 3 carry the address `{locality[3:0], offset[11:0]}`, with the upper byte first and then the lower byte.
- R3: No frame carries more than MAX_FRAME (64) data bytes. A longer command is split into consecutive frames of 64 bytes, and the last frame carries the remainder. For example, 150 bytes go out as 64, 64 and 22, and 64 bytes go out as one frame.
- R4: If bit 0 of the byte received during header byte 3 is 1, the data phase follows at once. The frame is then exactly 4 plus N bytes long.
- R5: If that bit is 0, the engine clocks poll bytes one at a time until a received byte has bit 0 set. The frame is then 4 plus the number of poll bytes plus N bytes long. A ready flag on the 100th poll byte is still accepted.
- R6: If 100 poll bytes all read not-ready, the command ends with status 2 (timeout) and no data bytes are moved. Chip select is high when done is reported, and the engine accepts new commands afterwards.
- R7: Chip select stays low without a break from the first header bit to the last data bit of a frame, and goes high between frames. SCLK idles low while chip select is high. Bits are sent in SPI mode 0, MSB first.
- R8: A command with both direction bits set, or with neither set, ends with status 1 on the cycle after it is accepted, and chip select never goes low.
- R9: Read bytes appear on `rd_data` with a one-cycle `rd_valid` pulse each, in wire order across all frames.
- R10: Write bytes are taken from the write stream in order and sent on MOSI. MOSI is 0 during poll bytes and read data bytes. MISO is ignored during write data, so no read pulses occur.
- R11: `cmd_ready` is high only while not busy. `busy` holds from acceptance through the single-cycle `done` pulse, with status 0 for success. A zero-length command completes with status 0 and no bus activity.
- R12: When the write stream is empty in the middle of a frame, SCLK pauses and chip select stays low until the next byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_rd | input | 1 | Read request |
| cmd_wr | input | 1 | Write request |
| cmd_locality | input | 4 | Locality, placed in address bits 15:12 |
| cmd_offset | input | 12 | Register offset, address bits 11:0 |
| cmd_len | input | LEN_W | Total data bytes |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Engine takes the write byte this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Single-cycle strobe for rd_data |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |
| busy | output | 1 | Command in progress |
| done | output | 1 | Single-cycle completion strobe |
| err_code | output | 2 | Status: 0 ok, 1 bad direction, 2 timeout |

## Verification
If the remaining-byte counter is corrupted, the size field of the very next header shows it, and the frame also has the wrong byte count when chip select rises. Both are visible within one frame. A mis-stepped header index or poll counter shows up as a wrong tag or address byte, or as a timeout after a different number of poll bytes than the 100 allowed. Either appears before the frame closes. A stuck phase register shows at once as `cmd_ready` and `busy` disagreeing, or as a missing or doubled `done` pulse within a few cycles of the end of the command.

// File: rtl/tpmspi_pkg.sv
package tpmspi_pkg;

    localparam logic [7:0] FRAME_TAG = 8'hD4;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BAD_DIR = 2'd1,
        ST_TIMEOUT = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEADER,
        PH_POLL,
        PH_DATA,
        PH_CLOSE,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
    } req_t;

    function automatic logic [15:0] make_addr(input logic [3:0] loc, input logic [11:0] off);
        return {loc, off};
    endfunction

    // Header byte selected by position within the 4-byte preamble
    function automatic logic [7:0] hdr_byte(input req_t r, input logic [1:0] idx,
                                            input logic [6:0] size_m1);
        logic [7:0] b;
        case (idx)
            2'd0:    b = {r.rd, size_m1};
            2'd1:    b = FRAME_TAG;
            2'd2:    b = r.addr[15:8];
            default: b = r.addr[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tpmspi_byte_shift.sv
// One SPI mode-0 byte: MOSI set while SCLK low, MISO sampled on the rising edge.
module tpmspi_byte_shift #(
    parameter int DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic          run_q;
    logic          hi_q;
    logic          done_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;

    wire tick = (div_q == DW'(DIV_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            run_q  <= 1'b0;
            hi_q   <= 1'b0;
            done_q <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q <= 1'b1;
                    tx_q  <= tx;
                    div_q <= '0;
                    bit_q <= '0;
                    hi_q  <= 1'b0;
                end
            end else if (!tick) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                if (!hi_q) begin
                    hi_q <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    hi_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                        tx_q   <= '0;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign busy = run_q;
    assign done = done_q;
    assign rx   = rx_q;
    assign sclk = hi_q;
    assign mosi = tx_q[7];

endmodule

// File: rtl/tpmspi_len_split.sv
// Tracks bytes still owed and sizes the current frame.
module tpmspi_len_split #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 64,
    parameter int FL_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             advance,
    output logic [FL_W-1:0]  frame_len,
    output logic             has_more
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)          rem_q <= '0;
        else if (load)    rem_q <= len_in;
        else if (advance) rem_q <= rem_q - LEN_W'(frame_len);
    end

    assign frame_len = (rem_q > LEN_W'(MAX_FRAME)) ? FL_W'(MAX_FRAME) : FL_W'(rem_q);
    assign has_more  = (rem_q != '0);

endmodule

// File: rtl/tpmspi_frame_ctrl.sv
module tpmspi_frame_ctrl
    import tpmspi_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FL_W       = 7,
    parameter int WAIT_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [3:0]       cmd_locality,
    input  logic [11:0]      cmd_offset,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    input  logic             sh_busy,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output logic             sp_load,
    output logic             sp_advance,
    input  logic [FL_W-1:0]  frame_len,
    input  logic             has_more,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output status_e          status
);
    localparam int WC_W = $clog2(WAIT_LIMIT + 1);

    phase_e          phase_q;
    req_t            req_q;
    logic [1:0]      hdr_idx_q;
    logic [FL_W-1:0] cnt_q;
    logic [WC_W-1:0] wait_q;
    logic            issued_q;
    logic            cs_q;
    logic            done_q;
    logic            rdv_q;
    logic [7:0]      rdd_q;
    status_e         status_q;

    wire can_issue = !issued_q && !sh_busy;
    wire bad_dir   = (cmd_rd == cmd_wr);

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        wr_ready = 1'b0;
        case (phase_q)
            PH_HEADER: begin
                sh_start = can_issue;
                sh_tx    = hdr_byte(req_q, hdr_idx_q, 7'(frame_len - 1'b1));
            end
            PH_POLL: sh_start = can_issue;
            PH_DATA: begin
                if (req_q.rd) begin
                    sh_start = can_issue;
                end else begin
                    wr_ready = can_issue;
                    sh_start = can_issue && wr_valid;
                    sh_tx    = wr_data;
                end
            end
            default: ;
        endcase
    end

    assign sp_load    = (phase_q == PH_IDLE) && cmd_valid && !bad_dir && (cmd_len != '0);
    assign sp_advance = (phase_q == PH_DATA) && sh_done && ((cnt_q + 1'b1) == frame_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            req_q     <= '0;
            hdr_idx_q <= '0;
            cnt_q     <= '0;
            wait_q    <= '0;
            issued_q  <= 1'b0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
            rdv_q     <= 1'b0;
            rdd_q     <= '0;
            status_q  <= ST_OK;
        end else begin
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            if (sh_start)     issued_q <= 1'b1;
            else if (sh_done) issued_q <= 1'b0;

            case (phase_q)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        req_q <= '{rd: cmd_rd, addr: make_addr(cmd_locality, cmd_offset)};
                        if (bad_dir) begin
                            phase_q  <= PH_FINISH;
                            done_q   <= 1'b1;
                            status_q <= ST_BAD_DIR;
                        end else if (cmd_len == '0) begin
                            phase_q  <= PH_FINISH;
                            done_q   <= 1'b1;
                            status_q <= ST_OK;
                        end else begin
                            phase_q   <= PH_HEADER;
                            cs_q      <= 1'b0;
                            hdr_idx_q <= '0;
                        end
                    end
                end
                PH_HEADER: begin
                    if (sh_done) begin
                        if (hdr_idx_q == 2'd3) begin
                            cnt_q   <= '0;
                            wait_q  <= '0;
                            phase_q <= sh_rx[0] ? PH_DATA : PH_POLL;
                        end else begin
                            hdr_idx_q <= hdr_idx_q + 1'b1;
                        end
                    end
                end
                PH_POLL: begin
                    if (sh_done) begin
                        if (sh_rx[0]) begin
                            phase_q <= PH_DATA;
                        end else if (wait_q == WC_W'(WAIT_LIMIT - 1)) begin
                            cs_q     <= 1'b1;
                            done_q   <= 1'b1;
                            status_q <= ST_TIMEOUT;
                            phase_q  <= PH_FINISH;
                        end else begin
                            wait_q <= wait_q + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (sh_done) begin
                        if (req_q.rd) begin
                            rdv_q <= 1'b1;
                            rdd_q <= sh_rx;
                        end
                        cnt_q <= cnt_q + 1'b1;
                        if (sp_advance) begin
                            cs_q    <= 1'b1;
                            phase_q <= PH_CLOSE;
                        end
                    end
                end
                PH_CLOSE: begin
                    if (has_more) begin
                        cs_q      <= 1'b0;
                        hdr_idx_q <= '0;
                        phase_q   <= PH_HEADER;
                    end else begin
                        done_q   <= 1'b1;
                        status_q <= ST_OK;
                        phase_q  <= PH_FINISH;
                    end
                end
                PH_FINISH: phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    assign cmd_ready = (phase_q == PH_IDLE);
    assign busy      = (phase_q != PH_IDLE);
    assign cs_n      = cs_q;
    assign done      = done_q;
    assign status    = status_q;
    assign rd_data   = rdd_q;
    assign rd_valid  = rdv_q;

endmodule

// File: rtl/tpm_spi_seq.sv
module tpm_spi_seq
    import tpmspi_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_FRAME  = 64,
    parameter int WAIT_LIMIT = 100,
    parameter int DIV_HALF   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [3:0]       cmd_locality,
    input  logic [11:0]      cmd_offset,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err_code
);
    localparam int FL_W = $clog2(MAX_FRAME + 1);

    logic            sh_start;
    logic [7:0]      sh_tx;
    logic            sh_busy;
    logic            sh_done;
    logic [7:0]      sh_rx;
    logic            sp_load;
    logic            sp_advance;
    logic [FL_W-1:0] frame_len;
    logic            has_more;
    status_e         status;

    tpmspi_byte_shift #(.DIV_HALF(DIV_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .miso  (spi_miso)
    );

    tpmspi_len_split #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .FL_W(FL_W)) u_split (
        .clk       (clk),
        .rst       (rst),
        .load      (sp_load),
        .len_in    (cmd_len),
        .advance   (sp_advance),
        .frame_len (frame_len),
        .has_more  (has_more)
    );

    tpmspi_frame_ctrl #(.LEN_W(LEN_W), .FL_W(FL_W), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_rd       (cmd_rd),
        .cmd_wr       (cmd_wr),
        .cmd_locality (cmd_locality),
        .cmd_offset   (cmd_offset),
        .cmd_len      (cmd_len),
        .wr_data      (wr_data),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .sh_start     (sh_start),
        .sh_tx        (sh_tx),
        .sh_busy      (sh_busy),
        .sh_done      (sh_done),
        .sh_rx        (sh_rx),
        .sp_load      (sp_load),
        .sp_advance   (sp_advance),
        .frame_len    (frame_len),
        .has_more     (has_more),
        .cs_n         (spi_cs_n),
        .busy         (busy),
        .done         (done),
        .status       (status)
    );

    assign err_code = status;

endmodule

// File: rtl/tpm_spi_seq_chk.sv
module tpm_spi_seq_chk #(
    parameter int MAX_FRAME = 64,
    parameter int FL_W      = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            cmd_rd,
    input logic            cmd_wr,
    input logic            wr_ready,
    input logic            rd_valid,
    input logic            spi_sclk,
    input logic            spi_cs_n,
    input logic            busy,
    input logic            done,
    input logic [1:0]      err_code,
    input logic [FL_W-1:0] frame_len
);
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    assert_cs_busy_R7: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

    assert_frame_cap_R3: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> (frame_len != '0) && (frame_len <= FL_W'(MAX_FRAME)));

    assert_err_release_R6: assert property (@(posedge clk) disable iff (rst)
        (done && err_code != 2'd0) |-> spi_cs_n);

    assert_bad_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_rd == cmd_wr)) |=> (done && err_code == 2'd1 && spi_cs_n));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && cmd_ready));

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_rd_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    assert_wr_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !spi_cs_n);

endmodule

bind tpm_spi_seq tpm_spi_seq_chk #(.MAX_FRAME(64), .FL_W(7)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .frame_len (frame_len)
);

// File: tb/tb_tpm_spi_seq.sv
`timescale 1ns/1ps
module tb_tpm_spi_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_rd = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [3:0]  cmd_locality = '0;
    logic [11:0] cmd_offset = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic        busy;
    logic        done;
    logic [1:0]  err_code;

    always #10 clk = ~clk;

    tpm_spi_seq dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_locality(cmd_locality), .cmd_offset(cmd_offset), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .busy(busy), .done(done), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference state for the request in flight
    bit          exp_rd;
    logic [15:0] exp_addr;
    int          exp_rem;
    bit          exp_timeout;
    bit          in_req;
    int          t_wait_n;
    int          t_seed;
    int          t_served;
    bit          stall_on;
    bit          stall_tgl;
    logic [7:0]  src_q[$];
    logic [7:0]  wexp_q[$];
    logic [7:0]  got_q[$];
    logic [7:0]  fq[$];
    int          frames_started;
    int          frames_ended;
    int          done_cnt;

    // Target model: reply byte for position idx in the current frame
    function automatic logic [7:0] resp(input int idx);
        int ds;
        if (idx < 3) return 8'h00;
        if (idx == 3) return (t_wait_n == 0) ? 8'h01 : 8'h00;
        ds = (t_wait_n == 0) ? 4 : 4 + t_wait_n;
        if (idx < ds) return (idx == ds - 1) ? 8'h01 : 8'h00;
        if (exp_rd) return 8'(t_seed + t_served + idx - ds);
        return 8'hFF;
    endfunction

    logic [7:0] t_in;
    logic [7:0] t_out;
    int         t_bit;
    int         t_idx;
    bit         in_frame = 1'b0;

    always @(negedge spi_cs_n) begin
        in_frame = 1'b1;
        frames_started++;
        t_idx = 0;
        t_bit = 0;
        fq.delete();
        t_out = resp(0);
        spi_miso = t_out[7];
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            t_in = {t_in[6:0], spi_mosi};
            t_bit++;
            if (t_bit == 8) begin
                fq.push_back(t_in);
                t_bit = 0;
                t_idx++;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            t_out = resp(t_idx);
            spi_miso = t_out[7 - t_bit];
        end
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            in_frame = 1'b0;
            frame_end();
        end
    end

    task automatic frame_end();
        int flen;
        int ds;
        int sz;
        frames_ended++;
        flen = (exp_rem > 64) ? 64 : exp_rem;
        sz = fq.size();
        if (exp_timeout) begin
            chk(sz == 104, "R6", "timeout frame byte count", sz, 104);
            return;
        end
        ds = (t_wait_n == 0) ? 4 : 4 + t_wait_n;
        chk(sz == ds + flen, (t_wait_n == 0) ? "R4" : "R5", "frame byte count", sz, ds + flen);
        if (sz < 4) return;
        chk(fq[0] == {exp_rd, 7'(flen - 1)}, "R1", "header byte0", fq[0], {exp_rd, 7'(flen - 1)});
        chk(fq[1] == 8'hD4, "R1", "header tag", fq[1], 8'hD4);
        chk(fq[2] == exp_addr[15:8], "R2", "address high", fq[2], exp_addr[15:8]);
        chk(fq[3] == exp_addr[7:0], "R2", "address low", fq[3], exp_addr[7:0]);
        if (sz == ds + flen) begin
            for (int i = 4; i < ds; i++)
                chk(fq[i] == 8'h00, "R10", "mosi during poll", fq[i], 0);
            for (int i = 0; i < flen; i++) begin
                if (exp_rd) begin
                    chk(fq[ds + i] == 8'h00, "R10", "mosi during read", fq[ds + i], 0);
                end else begin
                    logic [7:0] e;
                    e = (wexp_q.size() > 0) ? wexp_q.pop_front() : 8'hXX;
                    chk(fq[ds + i] == e, "R10", "write byte on mosi", fq[ds + i], e);
                end
            end
        end
        exp_rem -= flen;
        if (exp_rd) t_served += flen;
    endtask

    // Write stream source
    always @(negedge clk) begin
        stall_tgl = ~stall_tgl;
        wr_valid = (src_q.size() > 0) && !(stall_on && stall_tgl);
        wr_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    end

    always @(posedge clk) begin
        if (wr_valid && wr_ready && src_q.size() > 0) void'(src_q.pop_front());
        if (rd_valid) got_q.push_back(rd_data);
    end

    // Per-clock comparison against the reference state
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            chk(!(spi_cs_n && spi_sclk), "R7", "sclk idle low while deselected", spi_sclk, 0);
            chk(cmd_ready == !busy, "R11", "ready vs busy", cmd_ready, !busy);
            chk(!(rd_valid && !exp_rd), "R10", "read strobe during write", rd_valid, 0);
            chk(!(done && !in_req), "R11", "done outside request", done, 0);
        end
    end

    task automatic run_req(input bit rd, input bit wr, input logic [3:0] loc,
                           input logic [11:0] off, input int len, input int waitn,
                           input int seed, input bit stall, output logic [1:0] code);
        exp_rd = rd && !wr;
        exp_addr = {loc, off};
        exp_rem = len;
        exp_timeout = (waitn > 100);
        t_wait_n = waitn;
        t_seed = seed;
        t_served = 0;
        stall_on = stall;
        frames_started = 0;
        frames_ended = 0;
        done_cnt = 0;
        got_q.delete();
        wexp_q.delete();
        src_q.delete();
        if (wr && !rd) begin
            for (int i = 0; i < len; i++) begin
                src_q.push_back(8'(seed + i * 7));
                wexp_q.push_back(8'(seed + i * 7));
            end
        end
        @(negedge clk);
        in_req = 1'b1;
        cmd_valid = 1'b1;
        cmd_rd = rd;
        cmd_wr = wr;
        cmd_locality = loc;
        cmd_offset = off;
        cmd_len = 16'(len);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        code = err_code;
        repeat (3) @(negedge clk);
        in_req = 1'b0;
        chk(done_cnt == 1, "R11", "single done pulse", done_cnt, 1);
        chk(!busy && cmd_ready, "R11", "idle after done", busy, 0);
        chk(spi_cs_n == 1'b1, "R7", "cs released after request", spi_cs_n, 1);
    endtask

    task automatic check_read(input int len, input int seed);
        chk(got_q.size() == len, "R9", "read byte count", got_q.size(), len);
        if (got_q.size() == len)
            for (int i = 0; i < len; i++)
                chk(got_q[i] == 8'(seed + i), "R9", "read byte order", got_q[i], 8'(seed + i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] code;
        stall_tgl = 1'b0;
        in_req = 1'b0;
        exp_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7", "reset cs", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R7", "reset sclk", spi_sclk, 0);
        chk(busy == 1'b0 && cmd_ready == 1'b1, "R11", "reset idle", busy, 0);
        chk(done == 1'b0, "R11", "reset done", done, 0);

        // R4 R1 R2 R10: short write, target ready at once
        run_req(1'b0, 1'b1, 4'h0, 12'h024, 4, 0, 8'h31, 1'b0, code);
        chk(code == 2'd0, "R4", "write status", code, 0);
        chk(frames_started == 1, "R4", "write frames", frames_started, 1);
        chk(src_q.size() == 0, "R10", "write stream drained", src_q.size(), 0);
        chk(got_q.size() == 0, "R10", "no read bytes in write", got_q.size(), 0);

        // R5 R9: read with three not-ready polls
        run_req(1'b1, 1'b0, 4'h2, 12'hF00, 4, 3, 8'h10, 1'b0, code);
        chk(code == 2'd0, "R5", "polled read status", code, 0);
        check_read(4, 8'h10);

        // R3: 150-byte read in 64/64/22
        run_req(1'b1, 1'b0, 4'h1, 12'h024, 150, 0, 8'h80, 1'b0, code);
        chk(frames_started == 3 && frames_ended == 3, "R3", "frames for 150", frames_started, 3);
        chk(exp_rem == 0, "R3", "bytes covered", exp_rem, 0);
        check_read(150, 8'h80);

        // R3 boundary: 64 then 65
        run_req(1'b1, 1'b0, 4'h0, 12'h018, 64, 0, 8'h05, 1'b0, code);
        chk(frames_started == 1, "R3", "frames for 64", frames_started, 1);
        check_read(64, 8'h05);
        run_req(1'b1, 1'b0, 4'h0, 12'h018, 65, 1, 8'h44, 1'b0, code);
        chk(frames_started == 2, "R3", "frames for 65", frames_started, 2);
        check_read(65, 8'h44);

        // R12 R3 R10: write 70 bytes with a stalling source and polling
        run_req(1'b0, 1'b1, 4'h3, 12'hABC, 70, 2, 8'h21, 1'b1, code);
        chk(code == 2'd0, "R12", "stalled write status", code, 0);
        chk(frames_started == 2, "R12", "stalled write frames", frames_started, 2);
        chk(wexp_q.size() == 0, "R12", "all write bytes seen", wexp_q.size(), 0);

        // R5 boundary: ready on the 100th poll byte
        run_req(1'b1, 1'b0, 4'h0, 12'h004, 2, 100, 8'hC0, 1'b0, code);
        chk(code == 2'd0, "R5", "ready at last poll", code, 0);
        check_read(2, 8'hC0);

        // R6: 100 not-ready polls
        run_req(1'b1, 1'b0, 4'h0, 12'h004, 2, 1000, 8'h00, 1'b0, code);
        chk(code == 2'd2, "R6", "timeout status", code, 2);
        chk(got_q.size() == 0, "R6", "no data after timeout", got_q.size(), 0);
        chk(frames_started == 1, "R6", "timeout frames", frames_started, 1);

        // R8: both and neither direction
        run_req(1'b1, 1'b1, 4'h0, 12'h000, 4, 0, 8'h00, 1'b0, code);
        chk(code == 2'd1, "R8", "both directions status", code, 1);
        chk(frames_started == 0, "R8", "no bus for both", frames_started, 0);
        run_req(1'b0, 1'b0, 4'h0, 12'h000, 4, 0, 8'h00, 1'b0, code);
        chk(code == 2'd1, "R8", "no direction status", code, 1);
        chk(frames_started == 0, "R8", "no bus for none", frames_started, 0);

        // R11: zero length
        run_req(1'b1, 1'b0, 4'h0, 12'h000, 0, 0, 8'h00, 1'b0, code);
        chk(code == 2'd0, "R11", "zero length status", code, 0);
        chk(frames_started == 0, "R11", "zero length bus idle", frames_started, 0);

        // R6: recovery after errors
        run_req(1'b1, 1'b0, 4'hF, 12'h123, 3, 0, 8'h77, 1'b0, code);
        chk(code == 2'd0, "R6", "read after errors", code, 0);
        check_read(3, 8'h77);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule